// File: doc/BRIEF.md
# SPI register access slave

This block lets an external controller read and write a bank of byte-wide configuration registers over a four-wire serial link. A frame opens when the active-low select falls. The first byte of a frame is a command: its two upper bits choose the access kind and its six lower bits give the starting register. Every byte after that is data. The register index moves up by one after each data byte, and it wraps at the top of the bank. Write frames commit each completed byte. Read frames return register contents most significant bit first.

All serial inputs are brought into the block clock domain through a synchronizer before any edge is detected. Serial clock edges are therefore events in that domain. The serial clock idles low. The controller changes its data line after a rising edge, and the block samples it on the falling edge. The returned data line is enabled only while read bits are being presented, so a controller can join both data wires into one. One configuration bit turns on a weak pull-down on the returned line whenever that line is released.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset every register reads 8'h00, `spi_miso_oe` is low and `spi_miso_pd` is low.
- R2: A frame whose command byte has upper bits 2'b00 and address A in bits 5..0, followed by a full data byte sampled MSB first on falling SCLK edges, stores that byte in register A.
- R3: Further data bytes in a write frame go to A+1, A+2 and so on, with the address wrapping from 63 to 0.
- R4: A command byte with upper bits 2'b01 and address A starts a read. Register A is returned MSB first. Each bit is updated after a rising SCLK edge, starting with the rising edge that follows the eighth command bit.
- R5: Further bytes in a read frame return A+1, A+2 and so on, with the address wrapping from 63 to 0.
- R6: `spi_miso_oe` is high only while the data bits of a read byte are presented. It is low during the command byte, from the eighth falling edge of each read byte until the next rising edge, and while select is high.
- R7: Command bytes with upper bits 2'b10 or 2'b11 change no register and never drive `spi_miso_oe` for the rest of the frame.
- R8: When select rises part way through a byte, that partial byte is discarded. The next frame starts again with a command byte.
- R9: `spi_miso_pd` equals bit 3 of register 1 while `spi_miso_oe` is low, and it is low while `spi_miso_oe` is high.
- R10: `reg_q[8*a+7:8*a]` always shows the current contents of register a.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; it must run several times faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_ss_n | input | 1 | Active-low frame select from the controller |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the controller |
| spi_miso | output | 1 | Serial read data to the pad |
| spi_miso_oe | output | 1 | Output enable of the read-data pad driver |
| spi_miso_pd | output | 1 | Weak pull-down enable for the released read-data pad |
| reg_q | output | 512 | Contents of all 64 registers, register a in bits 8a+7..8a |

## Verification
A bit counter that is off by one, or an address that is wrong, appears in the same frame. It shows up either as a data byte landing in a neighbouring slice of `reg_q`, or as read bits shifted by one position when the controller samples them. A frame state that survives a select release appears in the next frame: a command byte gets stored as data, or nothing is returned at all. A stuck output enable appears between read bytes, or in the idle pull-down state, within one SCLK period.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

   // Phase of the current select frame
   typedef enum logic [1:0] {
      ST_CMD  = 2'd0,
      ST_WR   = 2'd1,
      ST_RD   = 2'd2,
      ST_SKIP = 2'd3
   } frame_st_t;

   // Bit order of the synchronised input bundle
   localparam int IN_SS   = 0;
   localparam int IN_SCLK = 1;
   localparam int IN_MOSI = 2;
   localparam int IN_W    = 3;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync
   import spi_reg_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ss_n,
   input  logic sclk,
   input  logic mosi,
   output logic ss_on,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic mosi_s
);

   localparam logic [IN_W-1:0] IDLE_VEC = IN_W'(1) << IN_SS;

   logic [STAGES-1:0][IN_W-1:0] pipe;
   logic [IN_W-1:0]             raw;
   logic [IN_W-1:0]             cur;
   logic                        sclk_d;

   always_comb begin
      raw          = '0;
      raw[IN_SS]   = ss_n;
      raw[IN_SCLK] = sclk;
      raw[IN_MOSI] = mosi;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe   <= {STAGES{IDLE_VEC}};
         sclk_d <= 1'b0;
      end else begin
         pipe   <= {pipe[STAGES-2:0], raw};
         sclk_d <= pipe[STAGES-1][IN_SCLK];
      end
   end

   assign cur       = pipe[STAGES-1];
   assign ss_on     = ~cur[IN_SS];
   assign mosi_s    = cur[IN_MOSI];
   assign sclk_rise = ss_on &  cur[IN_SCLK] & ~sclk_d;
   assign sclk_fall = ss_on & ~cur[IN_SCLK] &  sclk_d;

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
   import spi_reg_pkg::*;
#(
   parameter int                ADDR_W  = 6,
   parameter int                DATA_W  = 8,
   parameter int                MODE_W  = 2,
   parameter logic [MODE_W-1:0] WR_CODE = '0,
   parameter logic [MODE_W-1:0] RD_CODE = MODE_W'(1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ss_on,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi_s,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] addr,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic              miso,
   output logic              miso_oe,
   output frame_st_t         frame_state
);

   localparam int                CNT_W    = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   frame_st_t          state;
   logic [CNT_W-1:0]   bit_cnt;
   logic [DATA_W-2:0]  rx_sh;
   logic [DATA_W-2:0]  tx_sh;
   logic [ADDR_W-1:0]  addr_q;
   logic               miso_q;
   logic               oe_q;
   logic [DATA_W-1:0]  byte_in;
   logic               byte_done;
   logic [MODE_W-1:0]  cmd_mode;

   assign byte_in   = {rx_sh, mosi_s};
   assign byte_done = sclk_fall && (bit_cnt == LAST_BIT);
   assign cmd_mode  = byte_in[DATA_W-1 -: MODE_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_CMD;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         addr_q  <= '0;
         miso_q  <= 1'b0;
         oe_q    <= 1'b0;
      end else if (!ss_on) begin
         state   <= ST_CMD;
         bit_cnt <= '0;
         rx_sh   <= '0;
         miso_q  <= 1'b0;
         oe_q    <= 1'b0;
      end else begin
         if (sclk_fall) begin
            rx_sh   <= byte_in[DATA_W-2:0];
            bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
         end
         if (byte_done) begin
            unique case (state)
               ST_CMD: begin
                  addr_q <= byte_in[ADDR_W-1:0];
                  if (cmd_mode == WR_CODE)      state <= ST_WR;
                  else if (cmd_mode == RD_CODE) state <= ST_RD;
                  else                          state <= ST_SKIP;
               end
               ST_WR: addr_q <= addr_q + 1'b1;
               ST_RD: begin
                  addr_q <= addr_q + 1'b1;
                  oe_q   <= 1'b0;
               end
               default: ;
            endcase
         end
         if (sclk_rise && state == ST_RD) begin
            oe_q <= 1'b1;
            if (bit_cnt == '0) begin
               miso_q <= rd_data[DATA_W-1];
               tx_sh  <= rd_data[DATA_W-2:0];
            end else begin
               miso_q <= tx_sh[DATA_W-2];
               tx_sh  <= {tx_sh[DATA_W-3:0], 1'b0};
            end
         end
      end
   end

   assign addr        = addr_q;
   assign wr_en       = byte_done && (state == ST_WR);
   assign wr_data     = byte_in;
   assign miso        = miso_q;
   assign miso_oe     = oe_q;
   assign frame_state = state;

endmodule

// File: rtl/spi_reg_array.sv
module spi_reg_array #(
   parameter int                ADDR_W    = 6,
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [ADDR_W-1:0]               addr,
   input  logic [DATA_W-1:0]               wdata,
   output logic [DATA_W-1:0]               rdata,
   output logic [(1<<ADDR_W)*DATA_W-1:0]   q_flat
);

   localparam int NREG = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              mem[g] <= RESET_VAL;
         else if (we && addr == ADDR_W'(g))       mem[g] <= wdata;
      end
      assign q_flat[g*DATA_W +: DATA_W] = mem[g];
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
   import spi_reg_pkg::*;
#(
   parameter int                ADDR_W       = 6,
   parameter int                DATA_W       = 8,
   parameter int                MODE_W       = 2,
   parameter int                SYNC_STAGES  = 2,
   parameter bit                HAS_PULLDOWN = 1'b1,
   parameter int                PD_ADDR      = 1,
   parameter int                PD_BIT       = 3,
   parameter logic [DATA_W-1:0] RESET_VAL    = '0,
   parameter logic [MODE_W-1:0] WR_CODE      = '0,
   parameter logic [MODE_W-1:0] RD_CODE      = MODE_W'(1)
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 spi_ss_n,
   input  logic                                 spi_sclk,
   input  logic                                 spi_mosi,
   output logic                                 spi_miso,
   output logic                                 spi_miso_oe,
   output logic                                 spi_miso_pd,
   output logic [(1<<ADDR_W)*DATA_W-1:0]        reg_q
);

   localparam int NREG = 1 << ADDR_W;

   if (DATA_W != MODE_W + ADDR_W) begin : g_bad_cmd
      $error("command byte must hold mode and address exactly");
   end
   if (DATA_W < 3) begin : g_bad_data
      $error("data width below 3 is not supported");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchroniser stages are required");
   end
   if (WR_CODE == RD_CODE) begin : g_bad_codes
      $error("write and read codes must differ");
   end
   if (PD_ADDR >= NREG || PD_BIT >= DATA_W) begin : g_bad_pd
      $error("pull-down control bit lies outside the bank");
   end

   logic              ss_on;
   logic              sclk_rise;
   logic              sclk_fall;
   logic              mosi_s;
   logic [ADDR_W-1:0] addr;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] rd_data;
   logic              miso_q;
   logic              oe;
   frame_st_t         frame_state;

   spi_in_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .ss_n      (spi_ss_n),
      .sclk      (spi_sclk),
      .mosi      (spi_mosi),
      .ss_on     (ss_on),
      .sclk_rise (sclk_rise),
      .sclk_fall (sclk_fall),
      .mosi_s    (mosi_s)
   );

   spi_frame_ctrl #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .MODE_W  (MODE_W),
      .WR_CODE (WR_CODE),
      .RD_CODE (RD_CODE)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ss_on       (ss_on),
      .sclk_rise   (sclk_rise),
      .sclk_fall   (sclk_fall),
      .mosi_s      (mosi_s),
      .rd_data     (rd_data),
      .addr        (addr),
      .wr_en       (wr_en),
      .wr_data     (wr_data),
      .miso        (miso_q),
      .miso_oe     (oe),
      .frame_state (frame_state)
   );

   spi_reg_array #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .RESET_VAL (RESET_VAL)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_en),
      .addr   (addr),
      .wdata  (wr_data),
      .rdata  (rd_data),
      .q_flat (reg_q)
   );

   assign spi_miso    = miso_q & oe;
   assign spi_miso_oe = oe;

   if (HAS_PULLDOWN) begin : g_pd
      assign spi_miso_pd = reg_q[PD_ADDR*DATA_W + PD_BIT] & ~oe;
   end else begin : g_no_pd
      assign spi_miso_pd = 1'b0;
   end

endmodule

// File: rtl/spi_regbank_slave_chk.sv
module spi_regbank_slave_chk
   import spi_reg_pkg::*;
#(
   parameter int QW = 512
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ss_on,
   input logic          sclk_rise,
   input logic          sclk_fall,
   input logic          wr_en,
   input frame_st_t     state,
   input logic          spi_miso,
   input logic          spi_miso_oe,
   input logic [QW-1:0] reg_q
);

   // R6
   oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      spi_miso_oe |-> ss_on);

   // R6
   oe_drop_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_miso_oe) |-> ($past(sclk_fall) || !$past(ss_on)));

   // R4
   oe_rise_on_sclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_miso_oe) |-> $past(sclk_rise));

   // R4
   miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_miso_oe && $past(spi_miso_oe) && !$past(sclk_rise)) |-> $stable(spi_miso));

   // R7
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> (!spi_miso_oe && !wr_en));

   // R10
   reg_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_q) |-> $past(wr_en));

   // R8
   no_write_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_on |-> !wr_en);

endmodule

bind spi_regbank_slave spi_regbank_slave_chk #(
   .QW (NREG*DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ss_on       (ss_on),
   .sclk_rise   (sclk_rise),
   .sclk_fall   (sclk_fall),
   .wr_en       (wr_en),
   .state       (frame_state),
   .spi_miso    (spi_miso),
   .spi_miso_oe (spi_miso_oe),
   .reg_q       (reg_q)
);

// File: tb/spi_regbank_slave_bench.sv
module spi_regbank_slave_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int NREG       = 64;
   localparam int WATCHDOG   = 150000;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ss_n = 1'b1;
   logic         sclk = 1'b0;
   logic         mosi = 1'b0;
   logic         miso;
   logic         miso_oe;
   logic         miso_pd;
   logic [511:0] reg_q;

   logic [7:0]   model [NREG];
   int           checks = 0;
   int           errors = 0;
   bit           done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_regbank_slave u_spi_regbank_slave (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_ss_n    (ss_n),
      .spi_sclk    (sclk),
      .spi_mosi    (mosi),
      .spi_miso    (miso),
      .spi_miso_oe (miso_oe),
      .spi_miso_pd (miso_pd),
      .reg_q       (reg_q)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [7:0] pattern(input int a);
      return 8'((a * 29 + 7) ^ (a << 5));
   endfunction

   task automatic check_bank(input string req);
      logic [511:0] exp;
      for (int a = 0; a < NREG; a++) exp[a*8 +: 8] = model[a];
      check(reg_q === exp, req, 64'(reg_q != exp), 64'd0);
   endtask

   task automatic frame_open();
      wait_clk(1);
      ss_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic frame_close();
      wait_clk(HALF);
      ss_n = 1'b1;
      wait_clk(HALF);
   endtask

   // Shift nbits of tx (MSB first); collect MISO sampled after each rising edge
   task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx,
                       output int oe_cnt, output int pd_bad);
      rx = '0; oe_cnt = 0; pd_bad = 0;
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = tx[i];
         sclk = 1'b1;
         wait_clk(HALF);
         rx = {rx[6:0], miso};
         if (miso_oe) oe_cnt++;
         if (miso_oe && miso_pd) pd_bad++;
         sclk = 1'b0;
         wait_clk(HALF);
      end
   endtask

   task automatic write_frame(input int addr, input logic [7:0] d [8], input int n);
      logic [7:0] rx; int oe_cnt; int pd_bad;
      frame_open();
      xfer({2'b00, 6'(addr)}, 8, rx, oe_cnt, pd_bad);
      for (int k = 0; k < n; k++) begin
         xfer(d[k], 8, rx, oe_cnt, pd_bad);
         model[(addr + k) % NREG] = d[k];
      end
      frame_close();
   endtask

   task automatic read_frame(input int addr, input int n, input string req);
      logic [7:0] rx; int oe_cnt; int pd_bad;
      frame_open();
      xfer({2'b01, 6'(addr)}, 8, rx, oe_cnt, pd_bad);
      // R6: no drive during the command byte
      check(oe_cnt == 0, "R6 cmd", 64'(oe_cnt), 64'd0);
      for (int k = 0; k < n; k++) begin
         xfer(8'h00, 8, rx, oe_cnt, pd_bad);
         check(rx === model[(addr + k) % NREG], req, 64'(rx), 64'(model[(addr + k) % NREG]));
         // R6: driven for all eight data bits, released after the byte
         check(oe_cnt == 8, "R6 data", 64'(oe_cnt), 64'd8);
         check(miso_oe == 1'b0, "R6 gap", 64'(miso_oe), 64'd0);
         // R9: pull-down off whenever driven
         check(pd_bad == 0, "R9 driven", 64'(pd_bad), 64'd0);
      end
      frame_close();
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] d [8];
      logic [7:0] rx; int oe_cnt; int pd_bad;
      for (int a = 0; a < NREG; a++) model[a] = 8'h00;
      wait_clk(5);
      // R1: reset state
      check(miso_oe == 1'b0, "R1 oe", 64'(miso_oe), 64'd0);
      check(miso_pd == 1'b0, "R1 pd", 64'(miso_pd), 64'd0);
      check_bank("R1 bank");
      rst_n = 1'b1;
      wait_clk(5);
      check_bank("R1 bank after release");

      // R2, R10: every address written once
      for (int a = 0; a < NREG; a++) begin
         d[0] = pattern(a);
         write_frame(a, d, 1);
         check(reg_q[a*8 +: 8] === model[a], "R2 R10 single write", 64'(reg_q[a*8 +: 8]), 64'(model[a]));
      end
      check_bank("R2 bank after sweep");
      // R9: idle pull-down follows bit 3 of register 1
      check(miso_pd == model[1][3], "R9 idle", 64'(miso_pd), 64'(model[1][3]));

      // R4: every address read once
      for (int a = 0; a < NREG; a++) read_frame(a, 1, "R4 single read");

      // R3: write burst across the top of the bank
      d[0] = 8'hA1; d[1] = 8'hB2; d[2] = 8'hC3; d[3] = 8'hD4;
      write_frame(62, d, 4);
      check_bank("R3 burst wrap write");
      d[0] = 8'h11; d[1] = 8'h22; d[2] = 8'h33;
      write_frame(20, d, 3);
      check_bank("R3 burst write");

      // R5: read burst across the top of the bank
      read_frame(61, 5, "R5 burst wrap read");
      read_frame(19, 5, "R5 burst read");

      // R7: reserved codes touch nothing and never drive
      for (int m = 2; m < 4; m++) begin
         int tot;
         frame_open();
         xfer({2'(m), 6'd5}, 8, rx, oe_cnt, pd_bad);
         tot = oe_cnt;
         xfer(8'h5C, 8, rx, oe_cnt, pd_bad);
         tot += oe_cnt;
         xfer(8'hE7, 8, rx, oe_cnt, pd_bad);
         tot += oe_cnt;
         frame_close();
         check(tot == 0, "R7 no drive", 64'(tot), 64'd0);
         check_bank("R7 no write");
      end

      // R8: partial data byte dropped
      frame_open();
      xfer({2'b00, 6'd9}, 8, rx, oe_cnt, pd_bad);
      xfer(8'hFF, 5, rx, oe_cnt, pd_bad);
      frame_close();
      check_bank("R8 partial data");
      // R8: partial command byte, then a fresh frame decodes normally
      frame_open();
      xfer({2'b01, 6'd3}, 3, rx, oe_cnt, pd_bad);
      frame_close();
      check(miso_oe == 1'b0, "R8 oe after abort", 64'(miso_oe), 64'd0);
      d[0] = 8'h5A;
      write_frame(10, d, 1);
      check_bank("R8 restart");
      read_frame(10, 1, "R8 restart read");

      // R9: pull-down enabled, then disabled
      d[0] = 8'h08;
      write_frame(1, d, 1);
      check(miso_pd == 1'b1, "R9 on", 64'(miso_pd), 64'd1);
      read_frame(1, 2, "R9 read with pd");
      check(miso_pd == 1'b1, "R9 back on", 64'(miso_pd), 64'd1);
      d[0] = 8'hF7;
      write_frame(1, d, 1);
      check(miso_pd == 1'b0, "R9 off", 64'(miso_pd), 64'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule